// File: doc/BRIEF.md
# Dual Programmable Reload Timer

The block holds two identical 32-bit down-counting timers, numbered 0 and 1, behind a single register port. Each timer has three registers: a control word, a live count and a reload value. An enabled timer decrements once per selected tick. It raises its own interrupt line for one cycle when the count moves from 1 to 0. It then either stops there (one-shot) or refills itself from the reload register on the next tick and keeps going (auto-reload). The tick source for each timer is the bus clock, either directly or divided by 4, 8 or 16. The divided ticks come from one free-running prescaler that both timers share.

Each timer can be locked so that only privileged bus accesses may change it. A user write that hits a locked timer changes nothing and produces a one-cycle error pulse. The register port is a plain control interface with no handshake: a write takes effect on the clock edge where `wr_en` is high, and `rd_data` follows `addr` combinationally. Address bit 2 picks the timer and bits 1:0 pick the register: 0 is the control word, 1 is the count, 2 is the reload value, and 3 reads zero and ignores writes.

Control word layout: bit 0 is enable, bit 1 selects auto-reload, bit 2 is the user-write lock, bits 4:3 select the tick (0: every cycle, 1: /4, 2: /8, 3: /16), and bit 5 is the terminal-count flag.

Top module: `dual_rld_timer`

## Requirements
- R1: After reset all six registers read 0, both `irq` bits are 0 and `wr_err` is 0.
- R2: A privileged write to any of the six registers reads back the written value (control bits 5:0 only, with bit 5 only clearable), at the address given by {timer, register}.
- R3: While control bit 0 is 0 the count holds its value and that timer's `irq` bit stays 0.
- R4: An enabled timer decrements once per tick; on the tick that takes the count from 1 to 0 its `irq` bit is high for exactly the following cycle.
- R5: With bit 1 at 0 (one-shot), the count stays at 0 after terminal count and no further interrupt occurs.
- R6: With bit 1 at 1, the count refills from the reload register on the tick after terminal count, so interrupts recur every reload+1 ticks.
- R7: Control bit 5 reads 1 from terminal count on until a control write with bit 5 at 0; writing it as 1 leaves it unchanged.
- R8: With bit 2 set, a user write (`priv`=0) to any register of that timer changes nothing and `wr_err` is high for the next cycle only; privileged writes are still accepted.
- R9: With bit 2 clear, user and privileged writes are both accepted and `wr_err` stays 0.
- R10: Tick select 0, 1, 2 and 3 give one tick per 1, 4, 8 and 16 bus cycles.
- R11: The two timers run independently: activity of one never drives the other's `irq` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| addr | input | 3 | {timer index, register select} |
| wr_data | input | 32 | Write data |
| priv | input | 1 | 1 = privileged access, 0 = user access |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 2 | Per-timer terminal-count pulse |
| wr_err | output | 1 | One-cycle pulse after a blocked user write |

## Verification
The bench sweeps one-shot counts from 1 to 6 on both timers and checks `irq` on every cycle. A design that fires one tick early or late, or holds the pulse for two cycles, fails there. A one-shot timer that wraps to all-ones instead of stopping is caught by reading the count back as 0 after terminal count. Auto-reload periods are measured for every tick select and several reload values. An off-by-one in the refill (R ticks instead of R+1) or a wrong prescaler tap shows up as a wrong interval. The lock tests issue user writes to every register of a locked timer and read them back. They also check the error pulse length, so a lock that guards only some registers, or a sticky error line, is exposed. Sticky-flag tests write the flag as 1 and then as 0 to catch a flag cleared by any control write.

// File: rtl/dual_rld_timer_pkg.sv
package dual_rld_timer_pkg;

  // register select in addr[1:0]
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_RELOAD = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // control word, bit 5 down to bit 0
  typedef struct packed {
    logic       tc_flag;   // bit 5
    logic [1:0] tick_sel;  // bits 4:3
    logic       lock;      // bit 2
    logic       auto_rld;  // bit 1
    logic       en;        // bit 0
  } ctrl_t;

  localparam int CTRL_BITS  = 6;
  localparam int TC_BIT     = 5;
  localparam int N_TICK_SEL = 4;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int N_SEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [N_SEL-1:0] tick_vec
);
  // tap k>=1 fires once every 2^(k+1) cycles
  logic [N_SEL-1:0] ps_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_q + 1'b1;
  end

  assign tick_vec[0] = 1'b1;
  for (genvar k = 1; k < N_SEL; k++) begin : g_tap
    assign tick_vec[k] = &ps_q[k:0];
  end

  // R10: a slower tap only fires together with every faster one
  p_tap_nesting_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_vec[N_SEL-1] |-> (&tick_vec));

endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import dual_rld_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_TICK_SEL-1:0] tick_vec,
  input  logic                  wr_ok,
  input  reg_sel_e              wr_reg,
  input  logic [W-1:0]          wr_data,
  output ctrl_t                 ctrl,
  output logic [W-1:0]          count,
  output logic [W-1:0]          reload,
  output logic                  irq
);
  logic tick;
  assign tick = tick_vec[ctrl.tick_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      count  <= '0;
      reload <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_ok) begin
        // an accepted write to this timer pauses counting for that cycle
        case (wr_reg)
          REG_CTRL: begin
            ctrl.en       <= wr_data[0];
            ctrl.auto_rld <= wr_data[1];
            ctrl.lock     <= wr_data[2];
            ctrl.tick_sel <= wr_data[4:3];
            ctrl.tc_flag  <= ctrl.tc_flag & wr_data[TC_BIT];
          end
          REG_COUNT:  count  <= wr_data;
          REG_RELOAD: reload <= wr_data;
          default: ;
        endcase
      end else if (ctrl.en && tick) begin
        if (count == W'(1)) begin
          count        <= '0;
          irq          <= 1'b1;
          ctrl.tc_flag <= 1'b1;
        end else if (count == '0) begin
          if (ctrl.auto_rld) count <= reload;
        end else begin
          count <= count - W'(1);
        end
      end
    end
  end

  // R3: no interrupt from a disabled timer
  p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.en);
  // R3: disabled and untouched means frozen
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !wr_ok) |=> $stable(count));
  // R4: interrupt is a single-cycle pulse
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R5: one-shot timer parked at zero stays there
  p_oneshot_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.auto_rld && count == '0 && !wr_ok) |=> (count == '0));
  // R7: flag is visible whenever the pulse is
  p_flag_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl.tc_flag && count == '0));

endmodule

// File: rtl/dual_rld_timer.sv
module dual_rld_timer
  import dual_rld_timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int N_TIMERS = 2,
  localparam int IDX_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
  localparam int ADDR_W  = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [W-1:0]        wr_data,
  input  logic                priv,
  output logic [W-1:0]        rd_data,
  output logic [N_TIMERS-1:0] irq,
  output logic                wr_err
);
  logic [N_TICK_SEL-1:0] tick_vec;
  logic [IDX_W-1:0]      idx;
  reg_sel_e              rsel;
  logic                  reg_ok;
  logic [N_TIMERS-1:0]   hit, locked, wr_ok;
  ctrl_t                 ctrl_a   [N_TIMERS];
  logic [W-1:0]          count_a  [N_TIMERS];
  logic [W-1:0]          reload_a [N_TIMERS];

  assign idx    = addr[ADDR_W-1:2];
  assign rsel   = reg_sel_e'(addr[1:0]);
  assign reg_ok = (rsel != REG_NONE);

  timer_prescaler #(.N_SEL(N_TICK_SEL)) u_ps (
    .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    assign hit[i]    = wr_en && reg_ok && (idx == IDX_W'(i));
    assign locked[i] = ctrl_a[i].lock;
    assign wr_ok[i]  = hit[i] && (priv || !locked[i]);

    timer_unit #(.W(W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec),
      .wr_ok(wr_ok[i]), .wr_reg(rsel), .wr_data(wr_data),
      .ctrl(ctrl_a[i]), .count(count_a[i]), .reload(reload_a[i]),
      .irq(irq[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= |(hit & locked) && !priv;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (idx == IDX_W'(i)) begin
        case (rsel)
          REG_CTRL:   rd_data = W'(ctrl_a[i]);
          REG_COUNT:  rd_data = count_a[i];
          REG_RELOAD: rd_data = reload_a[i];
          default:    rd_data = '0;
        endcase
      end
    end
  end

  // R8: a blocked user write is always reported
  p_blocked_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv && |(hit & locked)) |=> wr_err);
  // R9: privileged writes never raise the error
  p_priv_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv) |=> !wr_err);
  // R8: at most one timer accepts a write per cycle
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_ok));

endmodule

// File: tb/dual_rld_timer_bench.sv
module dual_rld_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        priv = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  irq;
  logic        wr_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_rld_timer u_dual_rld_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .priv(priv), .rd_data(rd_data), .irq(irq), .wr_err(wr_err)
  );

  localparam logic [31:0] EN = 32'h1, AR = 32'h2, LK = 32'h4, TC = 32'h20;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write lands on the next posedge; returns at the negedge after it
  task automatic wr(input int t, input int r, input logic [31:0] d, input logic p);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(t * 4 + r); wr_data = d; priv = p;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b0;
  endtask

  task automatic rd(input int t, input int r, output logic [31:0] d);
    addr = 3'(t * 4 + r);
    #1 d = rd_data;
  endtask

  task automatic park(input int t);
    wr(t, 0, 32'h0, 1'b1);
    wr(t, 1, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 3; r++) begin
        rd(t, r, v); chk("R1 reg after reset", v, 0);
      end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wr_err", 32'(wr_err), 0);

    // R2 readback of every register
    wr(0, 2, 32'hA5A5_1234, 1'b1); rd(0, 2, v); chk("R2 reload0", v, 32'hA5A5_1234);
    wr(1, 2, 32'h0BAD_F00D, 1'b1); rd(1, 2, v); chk("R2 reload1", v, 32'h0BAD_F00D);
    wr(1, 1, 32'hFFFF_FFF0, 1'b1); rd(1, 1, v); chk("R2 count1", v, 32'hFFFF_FFF0);
    wr(1, 0, 32'h3E, 1'b1);        rd(1, 0, v); chk("R2 ctrl1 no tc set", v, 32'h1E);
    rd(1, 3, v); chk("R2 hole reads 0", v, 0);
    park(1);

    // R4 R5 R7 R11 one-shot sweep, both timers
    for (int t = 0; t < 2; t++)
      for (int c = 1; c <= 6; c++) begin
        wr(t, 1, 32'(c), 1'b1);
        wr(t, 0, EN, 1'b1);
        for (int k = 1; k <= c + 1; k++) begin
          @(negedge clk);
          chk("R4 irq timing", 32'(irq[t]), (k == c) ? 1 : 0);
          chk("R11 other timer quiet", 32'(irq[1-t]), 0);
        end
        repeat (6) begin
          @(negedge clk);
          chk("R5 no second irq", 32'(irq[t]), 0);
        end
        rd(t, 1, v); chk("R5 parked at zero", v, 0);
        rd(t, 0, v); chk("R7 flag set", v, TC | EN);
        wr(t, 0, TC, 1'b1); rd(t, 0, v); chk("R7 write 1 keeps flag", v, TC);
        wr(t, 0, 32'h0, 1'b1); rd(t, 0, v); chk("R7 write 0 clears flag", v, 0);
      end

    // R3 disabled timer holds
    wr(0, 1, 32'd10, 1'b1);
    wr(0, 0, AR, 1'b1);
    repeat (30) begin
      @(negedge clk);
      chk("R3 no irq while off", 32'(irq), 0);
    end
    rd(0, 1, v); chk("R3 count held", v, 10);
    park(0);

    // R6 R10 auto-reload period for every tick select
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 4; s++)
        for (int ri = 0; ri < 3; ri++) begin
          int rv, div, n;
          rv  = (ri == 0) ? 1 : (ri == 1) ? 2 : 4;
          div = (s == 0) ? 1 : (1 << (s + 1));
          wr(t, 2, 32'(rv), 1'b1);
          wr(t, 1, 32'(rv), 1'b1);
          wr(t, 0, EN | AR | 32'(s << 3), 1'b1);
          n = 0;
          while (!irq[t] && n < 400) begin @(negedge clk); n++; end
          n = 0;
          do begin @(negedge clk); n++; end while (!irq[t] && n < 400);
          chk("R6 R10 reload period", 32'(n), 32'((rv + 1) * div));
          park(t);
        end

    // R8 lock blocks user writes to all three registers
    wr(0, 2, 32'd9, 1'b1);
    wr(0, 0, LK, 1'b1);
    for (int r = 0; r < 3; r++) begin
      wr(0, r, 32'd77, 1'b0);
      chk("R8 err pulse", 32'(wr_err), 1);
      @(negedge clk);
      chk("R8 err one cycle", 32'(wr_err), 0);
    end
    rd(0, 0, v); chk("R8 ctrl unchanged", v, LK);
    rd(0, 1, v); chk("R8 count unchanged", v, 0);
    rd(0, 2, v); chk("R8 reload unchanged", v, 9);
    wr(0, 1, 32'd77, 1'b1);
    chk("R8 priv no err", 32'(wr_err), 0);
    rd(0, 1, v); chk("R8 priv write taken", v, 77);
    wr(0, 0, 32'h0, 1'b1); rd(0, 0, v); chk("R8 priv unlock", v, 0);

    // R9 unlocked user writes accepted
    wr(1, 1, 32'd55, 1'b0);
    chk("R9 no err", 32'(wr_err), 0);
    rd(1, 1, v); chk("R9 user count", v, 55);
    wr(1, 0, EN | AR, 1'b0);
    rd(1, 0, v); chk("R9 user ctrl", v, EN | AR);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule